// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from one asynchronous serial line. A strobe at sixteen times the baud rate paces every decision. The line first passes through a two-flop synchronizer. An optional stability filter follows it, and behind that sits a framing state machine. The machine qualifies a start bit, samples each bit at its centre and assembles a byte, least significant bit first. It can also check an even or odd parity bit and the stop bit.

Results leave on registered outputs. The byte and a one-clock valid strobe come out together, with single-cycle parity-error and frame-error pulses in the same cycle. A separate counter watches for a held-low line. It counts consecutive all-zero characters that fail their stop bit. Once the count passes a selectable threshold it emits one break pulse, and it arms again only after the line has gone back high.

Top module: `uart_os_rx`

## Requirements
- R1: A character is a low start bit, then the data bits least significant first, then the optional parity bit, then a high stop bit. Each bit is sampled once, at oversample tick 8 of 16 counted from the qualified start edge. `rx_valid` is high for exactly one clock after the stop bit is sampled, and `rx_data` carries the byte in that cycle.
- R2: With `par_en`=1, the parity bit is expected to be the XOR of the data bits when `par_odd`=0 (even) and its inverse when `par_odd`=1 (odd). A matching parity bit produces no `par_err`.
- R3: With `par_en`=1, a parity bit that does not match raises `par_err` for one clock, together with `rx_valid`. `par_err` never rises while `par_en`=0.
- R4: A stop bit sampled low raises `frm_err` for one clock, together with `rx_valid`. This holds with parity on and with parity off.
- R5: A start bit must stay low for half a bit period (8 ticks). If the line goes high sooner, the start is dropped, no character is produced, and the next character is received correctly. This check cannot be disabled.
- R6: With `filt_en`=1, a level change is accepted only after 3 consecutive ticks at the new level. Pulses of 2 ticks or fewer are ignored, both on an idle line and inside a data bit.
- R7: With `filt_en`=0, the synchronized level is taken on every tick. A 4-tick pulse that covers a bit's sampling point changes that bit.
- R8: `brk_sel` picks a break threshold N = 2, 4, 8 or 16 for the codes 0, 1, 2, 3. `brk_err` pulses for one clock in the cycle after the (N+1)-th consecutive character that has zero data and a frame error.
- R9: `brk_err` fires once per held-low condition. It fires again only after the filtered line has been seen high, which also clears the character count.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-clock strobe at 16x baud rate |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| filt_en | input | 1 | Enables the 3-tick stability filter |
| brk_sel | input | 2 | Break threshold code (2, 4, 8, 16 characters) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-clock strobe per received character |
| par_err | output | 1 | Parity mismatch pulse |
| frm_err | output | 1 | Stop-bit-low pulse |
| brk_err | output | 1 | Break detected pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit character, 16x oversampling, a 3-tick filter and a 2-bit threshold code. It drives the tick every fourth clock, so one bit period is 64 clocks. That spacing allows a 2-tick glitch, a 4-tick pulse and a 6-tick short start to be placed precisely within a bit. Threshold codes 0 and 1 keep break runs to a few thousand clocks, while the frame count at which the pulse fires still pins down the comparison.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  function automatic logic expected_parity(input logic data_xor, input logic odd);
    return data_xor ^ odd;
  endfunction

endpackage

// File: rtl/uart_rx_filter.sv
module uart_rx_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_i,
  input  logic filt_en,
  output logic line_o
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic [FILT_LEN-1:0]    window;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign window = {hist_q, sync_q[SYNC_STAGES-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '1;
      line_o <= 1'b1;
    end else if (tick) begin
      hist_q <= window[HIST_W-1:0];
      if (!filt_en)        line_o <= sync_q[SYNC_STAGES-1];
      else if (&window)    line_o <= 1'b1;
      else if (~|window)   line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line_i,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_bit_q;
  logic              at_mid;

  assign at_mid = (cnt_q == FULL_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      par_bit_q <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (!line_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (line_i) begin
              state_q <= RX_IDLE;
            end else if (cnt_q == HALF_END) begin
              state_q <= RX_DATA;
              cnt_q   <= '0;
              idx_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_mid) begin
              cnt_q   <= '0;
              shreg_q <= {line_i, shreg_q[DATA_W-1:1]};
              if (idx_q == LAST_IDX) state_q <= par_en ? RX_PAR : RX_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_mid) begin
              cnt_q     <= '0;
              par_bit_q <= line_i;
              state_q   <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_mid) begin
              cnt_q     <= '0;
              state_q   <= RX_IDLE;
              data_o    <= shreg_q;
              valid_o   <= 1'b1;
              frm_err_o <= !line_i;
              par_err_o <= par_en &&
                           (par_bit_q != expected_parity(^shreg_q, par_odd));
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break #(
  parameter int SEL_W = 2,
  parameter int BASE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line_i,
  input  logic             frame_done,
  input  logic             frame_err,
  input  logic             frame_zero,
  input  logic [SEL_W-1:0] sel,
  output logic             brk_o
);
  localparam int MAX_LIM = BASE << ((1 << SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LIM + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             armed_q;

  assign limit = CNT_W'(BASE) << sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      brk_o   <= 1'b0;
    end else begin
      brk_o <= 1'b0;
      if (tick && line_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (frame_done) begin
        if (frame_err && frame_zero) begin
          if (cnt_q <= limit) cnt_q <= cnt_q + 1'b1;
          if (cnt_q == limit && armed_q) begin
            brk_o   <= 1'b1;
            armed_q <= 1'b0;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int SEL_W       = 2,
  parameter int BRK_BASE    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_i,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              filt_en,
  input  logic [SEL_W-1:0]  brk_sel,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_err
);
  logic line;

  uart_rx_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .tick(tick16), .rx_i(rx_i),
    .filt_en(filt_en), .line_o(line)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .line_i(line),
    .par_en(par_en), .par_odd(par_odd),
    .data_o(rx_data), .valid_o(rx_valid),
    .par_err_o(par_err), .frm_err_o(frm_err)
  );

  uart_rx_break #(.SEL_W(SEL_W), .BASE(BRK_BASE)) u_brk (
    .clk(clk), .rst(rst), .tick(tick16), .line_i(line),
    .frame_done(rx_valid), .frame_err(frm_err),
    .frame_zero(rx_data == '0), .sel(brk_sel), .brk_o(brk_err)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              par_en,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              par_err,
  input logic              frm_err,
  input logic              brk_err
);
  // R1
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R3
  par_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    par_err |-> (rx_valid && par_en));

  // R4
  frm_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frm_err |-> rx_valid);

  // R8
  brk_after_zero_frame_chk: assert property (@(posedge clk) disable iff (rst)
    brk_err |-> ($past(frm_err) && ($past(rx_data) == '0)));

  // R9
  brk_single_chk: assert property (@(posedge clk) disable iff (rst)
    brk_err |=> !brk_err);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .par_en(par_en), .rx_data(rx_data),
  .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err), .brk_err(brk_err)
);

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_i = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       filt_en = 1'b0;
  logic [1:0] brk_sel = 2'd0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err, brk_err;

  int n_chk = 0;
  int n_bad = 0;
  int vcnt = 0, pecnt = 0, fecnt = 0, bkcnt = 0, fe_at_brk = 0;
  logic [7:0] last_data = '0;

  localparam int BIT = 64;

  always #2 clk = ~clk;

  uart_os_rx dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_i(rx_i),
    .par_en(par_en), .par_odd(par_odd), .filt_en(filt_en), .brk_sel(brk_sel),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .brk_err(brk_err)
  );

  initial begin
    forever begin
      @(negedge clk) tick16 = 1'b1;
      @(negedge clk) tick16 = 1'b0;
      repeat (2) @(negedge clk);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        vcnt = vcnt + 1;
        last_data = rx_data;
        if (par_err) pecnt = pecnt + 1;
        if (frm_err) fecnt = fecnt + 1;
      end
      if (brk_err) begin
        bkcnt = bkcnt + 1;
        fe_at_brk = fecnt;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit with_par, input logic pbit,
                            input bit good_stop, input int gbit, input int glen);
    drive(1'b0, BIT);
    for (int i = 0; i < 8; i++) begin
      if (i == gbit) begin
        drive(d[i], 28);
        drive(~d[i], glen);
        drive(d[i], 36 - glen);
      end else begin
        drive(d[i], BIT);
      end
    end
    if (with_par) drive(pbit, BIT);
    if (good_stop) drive(1'b1, BIT);
    else           drive(1'b0, 48);
    drive(1'b1, 2 * BIT);
  endtask

  task automatic expect_char(input string req, input int v0, input logic [7:0] exp_d);
    chk(req, vcnt - v0, 1);
    chk(req, int'(last_data), int'(exp_d));
  endtask

  task automatic t_reset();
    // R10
    chk("R10", int'({rx_data, rx_valid, par_err, frm_err, brk_err}), 0);
  endtask

  task automatic t_basic();
    logic [7:0] pats [3] = '{8'hA5, 8'h01, 8'h80};
    par_en = 0; filt_en = 0;
    foreach (pats[k]) begin
      int v0 = vcnt, p0 = pecnt, f0 = fecnt;
      send_frame(pats[k], 0, 1'b0, 1, -1, 0);
      expect_char("R1", v0, pats[k]);
      chk("R1 no error", (pecnt - p0) + (fecnt - f0), 0);
    end
  endtask

  task automatic t_parity();
    int v0, p0;
    par_en = 1;
    // R2: even parity bit = XOR of data
    par_odd = 0; v0 = vcnt; p0 = pecnt;
    send_frame(8'h37, 1, ^8'h37, 1, -1, 0);
    expect_char("R2 even", v0, 8'h37);
    chk("R2 even", pecnt - p0, 0);
    // R2: odd parity bit = inverted XOR
    par_odd = 1; v0 = vcnt; p0 = pecnt;
    send_frame(8'h37, 1, ~^8'h37, 1, -1, 0);
    expect_char("R2 odd", v0, 8'h37);
    chk("R2 odd", pecnt - p0, 0);
    // R3: mismatch
    v0 = vcnt; p0 = pecnt;
    send_frame(8'h5C, 1, ^8'h5C, 1, -1, 0);
    expect_char("R3", v0, 8'h5C);
    chk("R3 pulse", pecnt - p0, 1);
    par_odd = 0; p0 = pecnt;
    send_frame(8'h5C, 1, ~^8'h5C, 1, -1, 0);
    chk("R3 even mismatch", pecnt - p0, 1);
    par_en = 0;
  endtask

  task automatic t_frame();
    int v0, f0;
    par_en = 0; v0 = vcnt; f0 = fecnt;
    send_frame(8'h6E, 0, 1'b0, 0, -1, 0);
    expect_char("R4 no parity", v0, 8'h6E);
    chk("R4 no parity", fecnt - f0, 1);
    par_en = 1; par_odd = 0; v0 = vcnt; f0 = fecnt;
    send_frame(8'h6E, 1, ^8'h6E, 0, -1, 0);
    expect_char("R4 parity", v0, 8'h6E);
    chk("R4 parity", fecnt - f0, 1);
    par_en = 0;
  endtask

  task automatic t_start_qual();
    int v0;
    filt_en = 0; v0 = vcnt;
    drive(1'b0, 16); drive(1'b1, 2 * BIT);
    drive(1'b0, 24); drive(1'b1, 2 * BIT);
    chk("R5 short start dropped", vcnt - v0, 0);
    v0 = vcnt;
    send_frame(8'h5A, 0, 1'b0, 1, -1, 0);
    expect_char("R5 next char", v0, 8'h5A);
  endtask

  task automatic t_filter();
    int v0;
    filt_en = 1; v0 = vcnt;
    for (int g = 0; g < 4; g++) begin
      drive(1'b0, 8); drive(1'b1, 40);
    end
    drive(1'b1, BIT);
    chk("R6 idle glitches", vcnt - v0, 0);
    v0 = vcnt;
    send_frame(8'hC3, 0, 1'b0, 1, -1, 0);
    expect_char("R6 after glitches", v0, 8'hC3);
    v0 = vcnt;
    send_frame(8'h96, 0, 1'b0, 1, 3, 8);
    expect_char("R6 in-bit glitch", v0, 8'h96);
    // R7: filter off lets a 4-tick pulse over the sample point flip bit 3
    filt_en = 0; v0 = vcnt;
    send_frame(8'h96, 0, 1'b0, 1, 3, 16);
    expect_char("R7 bit flipped", v0, 8'h9E);
  endtask

  task automatic t_break(input logic [1:0] sel);
    int b0, f0;
    int lim = 2 << sel;
    brk_sel = sel; par_en = 0; filt_en = 0;
    for (int run = 0; run < 2; run++) begin
      b0 = bkcnt; f0 = fecnt;
      drive(1'b0, 5500);
      // R8
      chk("R8 threshold", fe_at_brk - f0, lim + 1);
      // R9
      chk("R9 once per break", bkcnt - b0, 1);
      drive(1'b1, 1500);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_frame();
    t_start_qual();
    t_filter();
    t_break(2'd0);
    t_break(2'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule